// File: doc/BRIEF.md
# Upstream Pullup Enable Delay Timer

This block decides when the upstream data-plus pullup of a full-speed hub may be connected. While the pullup output is floating, the host cannot see the hub. The block keeps the output floating for a fixed delay after the system reset is released. It then drives the output high and keeps it high. A change of the power-source select level in either direction restarts the same delay and floats the output again. The hub therefore reconnects cleanly when its supply moves between bus power and local power.

The power-source select is an asynchronous level. It is low for bus-powered operation and high for self-powered operation. It passes through a synchroniser, and both of its edges are detected on the synchronised value. The level present while reset is asserted, and during the first cycles after release, is the reference and does not count as a change. The delay is a parameter in core clock cycles. Its default of 720000 cycles gives 15 ms at 48 MHz.

A two-state controller drives the outputs:
- `ST_FLOAT`: the output enable is low.
- `ST_DRIVE`: the output is driven high.

Its transitions are:
- `FLOAT_TO_DRIVE`: taken when the delay counter sits at terminal count and no restart is pending.
- `DRIVE_TO_FLOAT`: taken on a detected select edge.
- `FLOAT_RESTART`: a select edge while floating, which stays in `ST_FLOAT` and clears the counter.

System reset forces `ST_FLOAT`. A USB bus reset on the upstream port has no input here and does not affect the timing.

Top module: `pullup_delay_ctrl`

## Requirements
- R1: While `rst_n` is low, `pu_oe` and `pu_drive` are both 0.
- R2: With `pwr_sel` held stable, `pu_oe` rises at the rising edge numbered DELAY_CYCLES+1 after `rst_n` is released. The first rising edge with `rst_n` high is numbered 1.
- R3: The delay counter saturates at terminal count. Once `pu_oe` is 1, it stays 1 until a select edge or a reset occurs.
- R4: A level change of `pwr_sel`, low to high or high to low, is acted on at the third rising edge after the change. The first of these is the edge that first samples the new level. From that edge on, `pu_oe` is 0.
- R5: After the edge at which a change is acted on, `pu_oe` rises DELAY_CYCLES+1 rising edges later. A further change inside that window restarts the full delay.
- R6: If a select edge is acted on at the same rising edge at which the delay would have expired, the restart wins. `pu_oe` stays 0, and the full delay starts again from that edge.
- R7: `pu_drive` is 1 whenever `pu_oe` is 1 and 0 whenever `pu_oe` is 0.
- R8: The `pwr_sel` level held during reset, and over the first three rising edges after release, is the reference level. It is not treated as a change, whatever its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low system reset, asynchronous assert |
| pwr_sel | input | 1 | Asynchronous power-source select: 0 bus-powered, 1 self-powered |
| pu_drive | output | 1 | Value driven onto the pullup pin (1 when driven) |
| pu_oe | output | 1 | Pullup output enable; 0 means the pin floats |

## Verification
The two functions that can meet in one cycle are the expiry of the delay counter and a restart from a detected select edge. The bench provokes this meeting by watching its own cycle count since the last restart. It toggles the select just early enough that the edge is acted on exactly at the would-be expiry edge. It then judges `pu_oe` every cycle against a model built only from the requirements. `pu_oe` must stay low through that edge and rise a full delay later. Random toggle spacing is also used, both shorter and longer than the delay. This brings near-coincidences and back-to-back restarts.

// File: rtl/pud_pkg.sv
package pud_pkg;

    // Controller states for the pullup enable
    typedef enum logic {
        ST_FLOAT = 1'b0,
        ST_DRIVE = 1'b1
    } pud_state_e;

endpackage

// File: rtl/pud_sync.sv
// Multi-stage synchroniser for an asynchronous level.
module pud_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= 1'b0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/pud_edge_det.sv
// Both-edge detector on a synchronised level, suppressed until the
// synchroniser and the history register carry real samples.
module pud_edge_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic toggle
);
    localparam int PRIME_W = STAGES + 1;

    logic               level_prev;
    logic [PRIME_W-1:0] prime_sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_prev <= 1'b0;
            prime_sr   <= '0;
        end else begin
            level_prev <= level;
            prime_sr   <= {prime_sr[PRIME_W-2:0], 1'b1};
        end
    end

    assign toggle = prime_sr[PRIME_W-1] & (level ^ level_prev);
endmodule

// File: rtl/pud_timer.sv
// Saturating delay counter with synchronous clear.
module pud_timer #(
    parameter int LIMIT = 720000,
    parameter int CNT_W = $clog2(LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    output logic             expired,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] TERMINAL = CNT_W'(LIMIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 count <= '0;
        else if (clear)             count <= '0;
        else if (count != TERMINAL) count <= count + 1'b1;
    end

    assign expired = (count == TERMINAL);
endmodule

// File: rtl/pullup_delay_ctrl.sv
module pullup_delay_ctrl
    import pud_pkg::*;
#(
    parameter int DELAY_CYCLES = 720000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_sel,
    output logic pu_drive,
    output logic pu_oe
);
    localparam int CNT_W = $clog2(DELAY_CYCLES + 1);

    logic             sel_sync;
    logic             restart;
    logic             timer_done;
    logic [CNT_W-1:0] count;
    pud_state_e       state_q;
    pud_state_e       state_d;

    pud_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pwr_sel),
        .q_sync  (sel_sync)
    );

    pud_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .level  (sel_sync),
        .toggle (restart)
    );

    pud_timer #(.LIMIT(DELAY_CYCLES), .CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (restart),
        .expired (timer_done),
        .count   (count)
    );

    // Next-state logic: a restart always takes priority over expiry
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FLOAT: begin
                if (!restart && timer_done) state_d = ST_DRIVE;   // FLOAT_TO_DRIVE
            end
            ST_DRIVE: begin
                if (restart) state_d = ST_FLOAT;                  // DRIVE_TO_FLOAT
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FLOAT;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        pu_oe    = 1'b0;
        pu_drive = 1'b0;
        unique case (state_q)
            ST_FLOAT: begin
                pu_oe    = 1'b0;
                pu_drive = 1'b0;
            end
            ST_DRIVE: begin
                pu_oe    = 1'b1;
                pu_drive = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/pud_checker.sv
module pud_checker #(
    parameter int DELAY_CYCLES = 720000,
    parameter int CNT_W        = $clog2(DELAY_CYCLES + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pu_oe,
    input logic             pu_drive,
    input logic             restart,
    input logic             timer_done,
    input logic [CNT_W-1:0] count
);
    // R1: floating while reset is held
    always @(posedge clk) begin
        if (rst_n === 1'b0) begin
            p_float_in_reset_r1: assert (pu_oe == 1'b0 && pu_drive == 1'b0)
                else $error("pu_oe or pu_drive active during reset");
        end
    end

    p_hold_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pu_oe && !restart) |=> pu_oe);

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DELAY_CYCLES));

    p_restart_floats_r4: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !pu_oe);

    p_rise_after_expiry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pu_oe) |-> ($past(timer_done) && !$past(restart)));

    p_restart_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && timer_done && !pu_oe) |=> !pu_oe);

    p_drive_tracks_oe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pu_drive == pu_oe);
endmodule

bind pullup_delay_ctrl pud_checker #(.DELAY_CYCLES(DELAY_CYCLES), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pu_oe      (pu_oe),
    .pu_drive   (pu_drive),
    .restart    (restart),
    .timer_done (timer_done),
    .count      (count)
);

// File: tb/test_pullup_delay_ctrl.sv
`timescale 1ns/1ps
module test_pullup_delay_ctrl;
    localparam int DLY = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_sel = 1'b0;
    logic pu_drive;
    logic pu_oe;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    // Reference model state, derived from the requirements
    int  n_since = 0;       // rising edges since reset release or last restart
    int  nsamp = 0;         // samples taken since reset release
    logic h0 = 0, h1 = 0, h2 = 0, h3 = 0;
    bit  restart_now = 0;
    string phase = "R1";

    pullup_delay_ctrl #(.DELAY_CYCLES(DLY), .SYNC_STAGES(2)) i_pullup_delay_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_sel  (pwr_sel),
        .pu_drive (pu_drive),
        .pu_oe    (pu_oe)
    );

    always #2.5 clk = ~clk;

    function automatic logic exp_oe(input int n, input logic rst_level);
        if (!rst_level) return 1'b0;
        return (n >= DLY + 1) ? 1'b1 : 1'b0;
    endfunction

    task automatic check(input string req, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    // One clock: model update at the rising edge, checks at the falling edge
    task automatic step();
        @(posedge clk);
        if (!rst_n) begin
            n_since = 0; nsamp = 0; restart_now = 0;
        end else begin
            nsamp++;
            h3 = h2; h2 = h1; h1 = h0; h0 = pwr_sel;
            restart_now = (nsamp >= 4) && (h2 != h3);
            if (restart_now) n_since = 0;
            else if (n_since < DLY + 1) n_since++;
        end
        @(negedge clk);
        check(restart_now ? "R4" : phase, pu_oe, exp_oe(n_since, rst_n), "pu_oe");
        check("R7", pu_drive, pu_oe, "pu_drive");
    endtask

    task automatic run(input int cycles);
        for (int i = 0; i < cycles; i++) step();
    endtask

    initial begin
        void'($urandom(32'd5150));
        // R8 and R1: select held high through reset
        pwr_sel = 1'b1;
        phase = "R1";
        run(4);
        rst_n = 1'b1;
        phase = "R8";
        run(6);
        // R2: first enable after reset
        phase = "R2";
        run(DLY);
        check("R2", pu_oe, 1'b1, "pu_oe after reset delay");
        // R3: saturation, stays high
        phase = "R3";
        run(3 * DLY);
        check("R3", pu_oe, 1'b1, "pu_oe held after saturation");
        // R4/R5: high to low change
        pwr_sel = 1'b0;
        phase = "R5";
        run(DLY + 10);
        // R4/R5: low to high, then a retoggle inside the window
        pwr_sel = 1'b1;
        run(DLY / 2);
        pwr_sel = 1'b0;
        run(DLY + 10);
        // R6: restart acted on at the would-be expiry edge
        pwr_sel = 1'b1;
        run(3);
        while (n_since != DLY - 2) step();
        pwr_sel = 1'b0;
        phase = "R6";
        run(3);
        check("R6", pu_oe, 1'b0, "pu_oe at coincident expiry");
        run(DLY + 5);
        check("R6", pu_oe, 1'b1, "pu_oe after restarted delay");
        // R1 mid-run reset with the select changing inside reset (R8)
        rst_n = 1'b0;
        phase = "R1";
        run(2);
        pwr_sel = ~pwr_sel;
        run(2);
        rst_n = 1'b1;
        phase = "R8";
        run(DLY + 5);
        // Random spacing, both shorter and longer than the delay
        phase = "R5";
        for (int k = 0; k < 40; k++) begin
            int gap;
            gap = 1 + int'($urandom_range(0, 3 * DLY));
            pwr_sel = ~pwr_sel;
            run(gap);
        end
        run(DLY + 5);
        finished = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule